// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character into a start-bit-framed asynchronous serial stream on a single output line. The line rests at logic 1. Each frame begins with a low start bit. The data bits follow, least significant first, then an optional parity bit, then a high stop time. The frame format is chosen at run time from three inputs: the data length (5 to 8 bits), the parity mode (none, odd, even, constant one or constant zero) and the stop length (1, 1.5 or 2 bit periods). The block only produces logic levels. Level shifting, flow-control pins and buffering are left to the surrounding design.

Bit timing comes from a free-running divider on the system clock. The divider is programmed in half-bit units, so the same time base can time a 1.5-bit stop. A character and its format are offered with a valid/ready handshake. The block raises ready for a single clock, and only on a full-bit boundary. It captures the data and the format at that transfer. A busy output stays high from the transfer until the stop time has ended. When valid is held high, a new frame can follow the previous stop time with no gap.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever busy is low, txd is 1 and busy is 0.
- R2: A frame on txd is a 0 start bit, then the data bits starting with in_data[0], then the parity bit if parity is enabled, then a stop time at 1. The start bit begins in the clock after the handshake transfer.
- R3: The code fmt_len selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of in_data above the selected length never reach txd.
- R4: The code fmt_par selects the parity: 0 none (no parity bit), 1 odd (data plus parity hold an odd number of ones), 2 even (an even number of ones), 3 a constant 1, 4 a constant 0. The codes 5 to 7 behave as none.
- R5: The code fmt_stop selects the stop time: 0 gives 1 bit period, 1 gives 1.5, and 2 or 3 give 2. Busy is high from the clock after the transfer for exactly T*H clocks, where T is the frame length in half bits and H is the half-bit length in clocks.
- R6: in_ready is high for one clock at a time, and only on a full-bit boundary. It can be high while busy only in the final half-bit of a frame. A transfer happens when in_valid and in_ready are both high.
- R7: The data and the format are captured at the transfer. Changes to in_data, fmt_len, fmt_par or fmt_stop during a frame have no effect on that frame.
- R8: When in_valid is held high and the stop length is 1 or 2 bits, the next start bit begins in the clock right after the previous stop time ends, and busy stays high throughout.
- R9: Each bit lasts 2*H clocks, where H is half_div. A half_div of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | Half-bit length in clocks (0 treated as 1) |
| fmt_len | input | LEN_W | Data length code |
| fmt_par | input | 3 | Parity mode code |
| fmt_stop | input | 2 | Stop length code |
| in_data | input | DATA_W | Character to send |
| in_valid | input | 1 | Character and format offered |
| in_ready | output | 1 | One-clock strobe: a character can be taken |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is in progress, stop time included |

## Verification
The assertions check four things on every cycle. The line is high whenever the block is idle. A transfer is followed by a low line and a raised busy. Ready never lasts two clocks. Ready never rises in the middle of a frame. Only the bench's scenarios can show that the whole waveform is correct, because that needs a reference decoder that knows the format: the order and value of every bit, the parity value for each mode, the lengths of 5 to 8 bits, the 1.5-bit stop and the exact busy duration. The same applies to capture at the transfer and to frames sent back to back.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   typedef enum logic [2:0] {
      PAR_NONE  = 3'd0,
      PAR_ODD   = 3'd1,
      PAR_EVEN  = 3'd2,
      PAR_ONE   = 3'd3,
      PAR_ZERO  = 3'd4
   } par_mode_e;

   // stop length in half-bit units for a stop code
   function automatic int stop_halves(input logic [1:0] code);
      case (code)
         2'd0:    return 2;
         2'd1:    return 3;
         default: return 4;
      endcase
   endfunction
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half_div,
   output logic             half_stb,
   output logic             full_stb
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim_m1;
   logic             phase;

   assign lim_m1   = (half_div > DIV_W'(1)) ? half_div - DIV_W'(1) : '0;
   assign half_stb = (cnt >= lim_m1);
   assign full_stb = half_stb & phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (half_stb) begin
         cnt   <= '0;
         phase <= ~phase;
      end else begin
         cnt   <= cnt + DIV_W'(1);
      end
   end
endmodule

// File: rtl/sertx_frame_build.sv
module sertx_frame_build
   import sertx_pkg::*;
#(
   parameter int MIN_LEN   = 5,
   parameter int LEN_W     = 2,
   parameter bit PARITY_EN = 1'b1,
   localparam int DATA_W   = MIN_LEN + (1 << LEN_W) - 1,
   localparam int SR_W     = DATA_W + 2,
   localparam int CNT_W    = $clog2(2 * SR_W + 5)
) (
   input  logic [DATA_W-1:0] data,
   input  logic [LEN_W-1:0]  len_code,
   input  logic [2:0]        par_code,
   input  logic [1:0]        stop_code,
   output logic [SR_W-1:0]   image,
   output logic [CNT_W-1:0]  halves
);
   int                nbits;
   logic [DATA_W-1:0] masked;
   logic              par_on;
   logic              par_bit;

   always_comb begin
      nbits  = MIN_LEN + int'(len_code);
      masked = '0;
      for (int i = 0; i < DATA_W; i++)
         if (i < nbits) masked[i] = data[i];
   end

   generate
      if (PARITY_EN) begin : g_par
         always_comb begin
            par_on  = 1'b1;
            par_bit = 1'b0;
            case (par_mode_e'(par_code))
               PAR_ODD:  par_bit = ~(^masked);
               PAR_EVEN: par_bit = ^masked;
               PAR_ONE:  par_bit = 1'b1;
               PAR_ZERO: par_bit = 1'b0;
               default:  par_on  = 1'b0;
            endcase
         end
      end else begin : g_nopar
         assign par_on  = 1'b0;
         assign par_bit = 1'b0;
      end
   endgenerate

   always_comb begin
      image    = '1;
      image[0] = 1'b0;
      for (int j = 1; j < SR_W; j++) begin
         if (j <= nbits)                 image[j] = masked[j-1];
         else if (par_on && j == nbits+1) image[j] = par_bit;
      end
      halves = CNT_W'(2 * (1 + nbits + int'(par_on)) + stop_halves(stop_code));
   end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
   parameter int SR_W  = 10,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SR_W-1:0]  image,
   input  logic [CNT_W-1:0] halves,
   input  logic             half_stb,
   input  logic             full_stb,
   output logic             txd,
   output logic             busy,
   output logic             last_half
);
   logic [SR_W-1:0]  sr;
   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr     <= '1;
         remain <= '0;
      end else if (load) begin
         sr     <= image;
         remain <= halves;
      end else begin
         if (half_stb && remain != '0) remain <= remain - CNT_W'(1);
         if (full_stb && remain != '0) sr <= {1'b1, sr[SR_W-1:1]};
      end
   end

   assign txd       = sr[0];
   assign busy      = (remain != '0);
   assign last_half = (remain == CNT_W'(1));
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
   parameter int DIV_W     = 16,
   parameter int MIN_LEN   = 5,
   parameter int LEN_W     = 2,
   parameter bit PARITY_EN = 1'b1,
   localparam int DATA_W   = MIN_LEN + (1 << LEN_W) - 1,
   localparam int SR_W     = DATA_W + 2,
   localparam int CNT_W    = $clog2(2 * SR_W + 5)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  half_div,
   input  logic [LEN_W-1:0]  fmt_len,
   input  logic [2:0]        fmt_par,
   input  logic [1:0]        fmt_stop,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              txd,
   output logic              busy
);
   generate
      if (DIV_W < 1)   begin : g_bad_div $error("DIV_W must be at least 1"); end
      if (MIN_LEN < 1) begin : g_bad_min $error("MIN_LEN must be at least 1"); end
      if (LEN_W < 1)   begin : g_bad_len $error("LEN_W must be at least 1"); end
   endgenerate

   logic             half_stb;
   logic             full_stb;
   logic             last_half;
   logic             accept;
   logic [SR_W-1:0]  image;
   logic [CNT_W-1:0] halves;

   sertx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .half_div (half_div),
      .half_stb (half_stb),
      .full_stb (full_stb)
   );

   sertx_frame_build #(
      .MIN_LEN   (MIN_LEN),
      .LEN_W     (LEN_W),
      .PARITY_EN (PARITY_EN)
   ) u_build (
      .data      (in_data),
      .len_code  (fmt_len),
      .par_code  (fmt_par),
      .stop_code (fmt_stop),
      .image     (image),
      .halves    (halves)
   );

   assign in_ready = full_stb & (~busy | last_half);
   assign accept   = in_valid & in_ready;

   sertx_shifter #(.SR_W(SR_W), .CNT_W(CNT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .image     (image),
      .halves    (halves),
      .half_stb  (half_stb),
      .full_stb  (full_stb),
      .txd       (txd),
      .busy      (busy),
      .last_half (last_half)
   );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic txd,
   input logic busy,
   input logic last_half
);
   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !txd);

   assert_busy_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> busy);

   assert_ready_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> !in_ready);

   assert_no_ready_midframe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && busy) |-> last_half);
endmodule

bind sertx_top sertx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .txd       (txd),
   .busy      (busy),
   .last_half (last_half)
);

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] half_div = 16'd3;
   logic [1:0]  fmt_len = 2'd3;
   logic [2:0]  fmt_par = 3'd0;
   logic [1:0]  fmt_stop = 2'd0;
   logic [7:0]  in_data = 8'h00;
   logic        in_valid = 1'b0;
   logic        in_ready, txd, busy;

   int vectors = 0;
   int errs = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sertx_top u_dut (
      .clk(clk), .rst_n(rst_n), .half_div(half_div), .fmt_len(fmt_len),
      .fmt_par(fmt_par), .fmt_stop(fmt_stop), .in_data(in_data),
      .in_valid(in_valid), .in_ready(in_ready), .txd(txd), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Reference frame image: bit 0 start, data, parity, ones after.
   task automatic ref_frame(input logic [7:0] d, input int len, input int par, input int stop,
                            output logic [15:0] fr, output int t_halves);
      int n = 5 + len;
      int ones = 0;
      bit pen = (par >= 1 && par <= 4);
      bit pb = 1'b0;
      fr = '1;
      fr[0] = 1'b0;
      for (int i = 0; i < n; i++) begin
         fr[i+1] = d[i];
         if (d[i]) ones++;
      end
      if (par == 1) pb = (ones % 2 == 0);
      if (par == 2) pb = (ones % 2 == 1);
      if (par == 3) pb = 1'b1;
      if (pen) fr[n+1] = pb;
      t_halves = 2 * (1 + n + int'(pen)) + ((stop == 0) ? 2 : (stop == 1) ? 3 : 4);
   endtask

   // Called at the negedge just after the transfer; ends at the negedge after the frame.
   task automatic check_frame(input logic [7:0] d, input int len, input int par, input int stop,
                              input int h, input bit b2b, input string req);
      logic [15:0] fr;
      int t, bad, first_i;
      bad = 0; first_i = -1;
      ref_frame(d, len, par, stop, fr, t);
      for (int i = 0; i < t * h; i++) begin
         if (txd !== fr[i / (2 * h)] || busy !== 1'b1) begin
            bad++;
            if (first_i < 0) first_i = i;
         end
         @(negedge clk);
      end
      chk(bad == 0, {req, " waveform"}, first_i, -1);
      if (b2b) chk(txd === 1'b0 && busy === 1'b1, "R8 next start directly after stop",
                   int'({txd, busy}), 1);
      else     chk(txd === 1'b1 && busy === 1'b0, {"R5 busy length/", req},
                   int'({txd, busy}), 2);
   endtask

   // Offer a character, wait for the transfer, land on the next negedge.
   task automatic offer(input logic [7:0] d, input int len, input int par, input int stop);
      int guard = 0;
      in_data = d; fmt_len = 2'(len); fmt_par = 3'(par); fmt_stop = 2'(stop);
      in_valid = 1'b1;
      while (in_ready !== 1'b1 && guard < 1000) begin
         @(negedge clk); guard++;
      end
      @(negedge clk);
   endtask

   task automatic scramble();
      in_valid = 1'b0; in_data = ~in_data; fmt_len = ~fmt_len; fmt_par = 3'd3; fmt_stop = ~fmt_stop;
   endtask

   task automatic t_reset();
      chk(txd === 1'b1 && busy === 1'b0, "R1 reset idle state", int'({txd, busy}), 2);
   endtask

   task automatic t_idle();
      int seen = 0, bad = 0;
      in_valid = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (in_ready === 1'b1) seen++;
         if (txd !== 1'b1 || busy !== 1'b0) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R1 idle line stays high", bad, 0);
      chk(seen > 0, "R6 ready pulses when idle", seen, 1);
   endtask

   task automatic t_frame(input logic [7:0] d, input int len, input int par, input int stop,
                          input string req);
      offer(d, len, par, stop);
      scramble();
      check_frame(d, len, par, stop, (half_div == 0) ? 1 : int'(half_div), 1'b0, req);
   endtask

   task automatic t_b2b();
      offer(8'hA5, 3, 0, 2);
      in_data = 8'h3C;
      check_frame(8'hA5, 3, 0, 2, int'(half_div), 1'b1, "R8 first frame");
      in_valid = 1'b0;
      check_frame(8'h3C, 3, 0, 2, int'(half_div), 1'b0, "R8 second frame");
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         vectors++; errs++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle();
      t_frame(8'h41, 3, 0, 0, "R2 8N1");
      t_frame(8'hFF, 0, 1, 0, "R3 R4 5-bit odd, upper bits ignored");
      t_frame(8'h2D, 1, 2, 1, "R4 R5 6-bit even, 1.5 stop");
      t_frame(8'h32, 2, 3, 2, "R4 7-bit parity one, 2 stop");
      t_frame(8'hC3, 3, 4, 3, "R4 8-bit parity zero");
      t_frame(8'h96, 3, 2, 0, "R4 8-bit even");
      t_frame(8'h5A, 3, 6, 0, "R4 unused code as none");
      t_frame(8'hE7, 1, 1, 1, "R7 capture at transfer");
      t_b2b();
      half_div = 16'd1;
      t_frame(8'h6B, 3, 1, 1, "R9 half_div 1");
      half_div = 16'd0;
      t_frame(8'h19, 2, 0, 0, "R9 half_div 0 as 1");
      half_div = 16'd5;
      t_frame(8'h80, 0, 2, 2, "R2 R9 half_div 5");
      t_idle();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end
endmodule